// File: doc/BRIEF.md
# Exclusive access monitor

This block holds the reservation behind load-exclusive / store-exclusive pairs issued by one processor port. A load-exclusive computes its effective address (a base plus an 8-bit offset field scaled by four), records that address and the access size, and arms the monitor. A later store-exclusive is allowed to write memory only if the monitor is still armed and the store matches the recorded address and size. The block returns a one-bit status, with 0 meaning the store was performed and 1 meaning it was refused.

The reservation is broken by a clear-exclusive command, by an exception-entry pulse, by any store-exclusive (pass or fail), and by a snooped write from another bus master to the reserved word. A store-exclusive presented in the same cycle as one of these breaking events fails. A new load-exclusive while armed replaces the recorded address and size. Only one of load-exclusive and store-exclusive is presented in a given cycle.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive records its effective address and size and arms the monitor, so a matching store-exclusive later passes.
- R2: A passing store-exclusive yields, one cycle after the request, status_valid_o=1, status_o=0, mem_wr_o=1 and mem_addr_o equal to the store's effective address; with no request, status_valid_o is 0 in the following cycle.
- R3: Sizes are encoded 2'b00 byte, 2'b01 halfword, 2'b10 word; a store-exclusive whose size differs from the recorded size fails.
- R4: A store-exclusive whose effective address differs from the recorded address fails.
- R5: A failing store-exclusive yields status_o=1 with mem_wr_o=0; a store-exclusive while the monitor is not armed fails.
- R6: A clear-exclusive command disarms the monitor, so the next store-exclusive fails; a clear in the same cycle as the store also makes it fail.
- R7: A snooped write whose address lies in the same aligned 4-byte word as the recorded address (address bits above bit 1 equal) disarms the monitor, also when it coincides with the store; a snooped write to another word leaves the reservation intact.
- R8: An exception-entry pulse disarms the monitor.
- R9: Every store-exclusive disarms the monitor, so a second store-exclusive without a new load-exclusive fails.
- R10: A load-exclusive while armed replaces the recorded address and size.
- R11: The effective address is base_i + 4*offs_i, modulo 2^AW, for offsets 0 to 255 (byte offsets 0 to 1020).
- R12: After reset the monitor is disarmed and status_valid_o, status_o and mem_wr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ldx_i | input | 1 | Load-exclusive request |
| stx_i | input | 1 | Store-exclusive request |
| clrx_i | input | 1 | Clear-exclusive command |
| exc_entry_i | input | 1 | Exception-entry pulse |
| base_i | input | AW | Base address of the request |
| offs_i | input | 8 | Word offset field, scaled by 4 |
| size_i | input | 2 | Access size (00 byte, 01 half, 10 word) |
| snoop_vld_i | input | 1 | Write seen from another master |
| snoop_addr_i | input | AW | Address of that write |
| status_valid_o | output | 1 | Status result valid |
| status_o | output | 1 | 0 = store performed, 1 = refused |
| mem_wr_o | output | 1 | Memory write issued |
| mem_addr_o | output | AW | Address of the memory write |

## Verification
The store-exclusive is tried against reservations that match exactly, differ only in size, differ only in address, and were disturbed in between by a clear, an exception, a snoop to the same word and a snoop to a neighbouring word; each separates one term of the pass condition from the others. Offset extremes and a base near the top of the address space tell the scaled offset add apart from an unscaled or non-wrapping one. Directed sequences then cover a store with no reservation, two stores after one load, a reload that moves the reservation, and breaking events that coincide with the store itself.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_EXCL = 1'b1
  } mon_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/excl_addr_gen.sv
module excl_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offs_i,
  output logic [AW-1:0] ea_o
);
  localparam int SW = OW + 2;
  logic [SW-1:0] byte_offs;

  assign byte_offs = {offs_i, 2'b00};
  // R11: scaled offset, wraps modulo 2^AW
  assign ea_o = base_i + AW'(byte_offs);
endmodule

// File: rtl/excl_resv_fsm.sv
module excl_resv_fsm
  import excl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ldx_i,
  input  logic          stx_i,
  input  logic          kill_i,
  input  logic [AW-1:0] ea_i,
  input  logic [1:0]    size_i,
  input  logic          snoop_vld_i,
  input  logic [AW-1:0] snoop_addr_i,
  output mon_state_e    state_o,
  output logic [AW-1:0] tag_addr_o,
  output logic [1:0]    tag_size_o,
  output logic          snoop_hit_o
);
  mon_state_e    state_q, state_d;
  logic [AW-1:0] tag_addr_q;
  logic [1:0]    tag_size_q;
  logic [AW-1:0] snoop_diff;

  // word-granular compare against the tag
  assign snoop_diff  = snoop_addr_i ^ tag_addr_q;
  assign snoop_hit_o = snoop_vld_i && (state_q == ST_EXCL) && ((snoop_diff >> 2) == '0);

  always_comb begin
    state_d = state_q;
    if (kill_i || stx_i)   state_d = ST_OPEN;
    else if (ldx_i)        state_d = ST_EXCL;
    else if (snoop_hit_o)  state_d = ST_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OPEN;
      tag_addr_q <= '0;
      tag_size_q <= SZ_BYTE;
    end else begin
      state_q <= state_d;
      if (ldx_i && !kill_i && !stx_i) begin
        tag_addr_q <= ea_i;
        tag_size_q <= size_i;
      end
    end
  end

  assign state_o    = state_q;
  assign tag_addr_o = tag_addr_q;
  assign tag_size_o = tag_size_q;

  a_r9_stx_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> state_q == ST_OPEN);
  a_r6_clr_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> state_q == ST_OPEN);
  a_r7_snoop_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit_o && !ldx_i) |=> state_q == ST_OPEN);
  a_r1_ldx_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldx_i && !stx_i && !kill_i) |=> (state_q == ST_EXCL && tag_size_q == $past(size_i)));
endmodule

// File: rtl/excl_stx_judge.sv
module excl_stx_judge
  import excl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stx_i,
  input  logic          kill_i,
  input  logic          snoop_hit_i,
  input  mon_state_e    state_i,
  input  logic [AW-1:0] tag_addr_i,
  input  logic [1:0]    tag_size_i,
  input  logic [AW-1:0] ea_i,
  input  logic [1:0]    size_i,
  output logic          status_valid_o,
  output logic          status_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o
);
  logic armed, match, pass;

  assign armed = (state_i == ST_EXCL) && !kill_i && !snoop_hit_i;
  assign match = (tag_addr_i == ea_i) && (tag_size_i == size_i);
  assign pass  = stx_i && armed && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_valid_o <= 1'b0;
      status_o       <= 1'b0;
      mem_wr_o       <= 1'b0;
      mem_addr_o     <= '0;
    end else begin
      status_valid_o <= stx_i;
      status_o       <= stx_i && !pass;
      mem_wr_o       <= pass;
      if (stx_i) mem_addr_o <= ea_i;
    end
  end

  a_r2_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> status_valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stx_i |=> !status_valid_o && !mem_wr_o);
  a_r5_fail_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> !mem_wr_o);
  a_r5_open_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && state_i == ST_OPEN) |=> status_o);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ldx_i,
  input  logic          stx_i,
  input  logic          clrx_i,
  input  logic          exc_entry_i,
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offs_i,
  input  logic [1:0]    size_i,
  input  logic          snoop_vld_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          status_valid_o,
  output logic          status_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o
);
  logic [AW-1:0] ea;
  logic          kill;
  mon_state_e    state;
  logic [AW-1:0] tag_addr;
  logic [1:0]    tag_size;
  logic          snoop_hit;

  assign kill = clrx_i || exc_entry_i;

  excl_addr_gen #(.AW(AW), .OW(OW)) u_addr (
    .base_i (base_i),
    .offs_i (offs_i),
    .ea_o   (ea)
  );

  excl_resv_fsm #(.AW(AW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ldx_i        (ldx_i),
    .stx_i        (stx_i),
    .kill_i       (kill),
    .ea_i         (ea),
    .size_i       (size_i),
    .snoop_vld_i  (snoop_vld_i),
    .snoop_addr_i (snoop_addr_i),
    .state_o      (state),
    .tag_addr_o   (tag_addr),
    .tag_size_o   (tag_size),
    .snoop_hit_o  (snoop_hit)
  );

  excl_stx_judge #(.AW(AW)) u_judge (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stx_i          (stx_i),
    .kill_i         (kill),
    .snoop_hit_i    (snoop_hit),
    .state_i        (state),
    .tag_addr_i     (tag_addr),
    .tag_size_i     (tag_size),
    .ea_i           (ea),
    .size_i         (size_i),
    .status_valid_o (status_valid_o),
    .status_o       (status_o),
    .mem_wr_o       (mem_wr_o),
    .mem_addr_o     (mem_addr_o)
  );

  a_r8_exc_no_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i |=> !mem_wr_o);
  a_r2_write_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o == $past(ea) && $past(state) == ST_EXCL));
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] lbase;
    logic [7:0]  lofs;
    logic [1:0]  lsize;
    logic [2:0]  ev;      // 0 none,1 clr,2 exc,3 snoop same word,4 snoop next word
    logic [31:0] sbase;
    logic [7:0]  sofs;
    logic [1:0]  ssize;
    logic        exp_st;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h1000,     8'd0,   2'b10, 3'd0, 32'h1000, 8'd0, 2'b10, 1'b0}, // R1 word
    '{32'h1000,     8'd4,   2'b01, 3'd0, 32'h1010, 8'd0, 2'b01, 1'b0}, // R11 half
    '{32'h2000,     8'd1,   2'b00, 3'd0, 32'h2004, 8'd0, 2'b00, 1'b0}, // R3 byte
    '{32'h2000,     8'd1,   2'b10, 3'd0, 32'h2000, 8'd1, 2'b01, 1'b1}, // R3 size
    '{32'h3000,     8'd0,   2'b10, 3'd0, 32'h3004, 8'd0, 2'b10, 1'b1}, // R4 addr
    '{32'h3000,     8'd2,   2'b10, 3'd1, 32'h3000, 8'd2, 2'b10, 1'b1}, // R6 clr
    '{32'h3100,     8'd0,   2'b10, 3'd2, 32'h3100, 8'd0, 2'b10, 1'b1}, // R8 exc
    '{32'h3200,     8'd3,   2'b10, 3'd3, 32'h3200, 8'd3, 2'b10, 1'b1}, // R7 same word
    '{32'h3200,     8'd3,   2'b10, 3'd4, 32'h3200, 8'd3, 2'b10, 1'b0}, // R7 other word
    '{32'h4000,     8'd255, 2'b10, 3'd0, 32'h43FC, 8'd0, 2'b10, 1'b0}, // R11 max ofs
    '{32'hFFFFFF00, 8'h80,  2'b10, 3'd0, 32'h100,  8'd0, 2'b10, 1'b0}, // R11 wrap
    '{32'h5000,     8'd0,   2'b01, 3'd0, 32'h5000, 8'd0, 2'b10, 1'b1}  // R3 half vs word
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ldx_i = 1'b0, stx_i = 1'b0, clrx_i = 1'b0, exc_entry_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [7:0]    offs_i = '0;
  logic [1:0]    size_i = '0;
  logic          snoop_vld_i = 1'b0;
  logic [AW-1:0] snoop_addr_i = '0;
  logic          status_valid_o, status_o, mem_wr_o;
  logic [AW-1:0] mem_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  excl_monitor #(.AW(AW), .OW(8)) u_dut (.*);

  function automatic logic [31:0] ea_of(logic [31:0] b, logic [7:0] o);
    return b + ({24'd0, o} << 2);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(logic ld, logic st, logic clr, logic exc, logic sv,
                      logic [31:0] b, logic [7:0] o, logic [1:0] sz, logic [31:0] sa);
    @(negedge clk_i);
    ldx_i = ld; stx_i = st; clrx_i = clr; exc_entry_i = exc;
    snoop_vld_i = sv; base_i = b; offs_i = o; size_i = sz; snoop_addr_i = sa;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, '0, '0, '0, '0);
  endtask

  task automatic ldx(logic [31:0] b, logic [7:0] o, logic [1:0] sz);
    step(1, 0, 0, 0, 0, b, o, sz, '0);
  endtask

  task automatic stx_chk(string req, logic [31:0] b, logic [7:0] o, logic [1:0] sz,
                         logic exp_st, logic clr, logic sv, logic [31:0] sa);
    step(0, 1, clr, 0, sv, b, o, sz, sa);
    check({req, " valid"}, {31'd0, status_valid_o}, 32'd1);
    check({req, " status"}, {31'd0, status_o}, {31'd0, exp_st});
    check({req, " wr"}, {31'd0, mem_wr_o}, {31'd0, !exp_st});
    if (!exp_st) check({req, " addr"}, mem_addr_o, ea_of(b, o));
  endtask

  initial begin : watchdog
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    // R12 reset state
    check("R12 valid", {31'd0, status_valid_o}, 32'd0);
    check("R12 status", {31'd0, status_o}, 32'd0);
    check("R12 wr", {31'd0, mem_wr_o}, 32'd0);
    rst_ni = 1'b1;
    idle();
    // R12 disarmed after reset: store fails
    stx_chk("R12", 32'h0, 8'd0, 2'b00, 1'b1, 0, 0, '0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [31:0] lea = ea_of(v.lbase, v.lofs);
      ldx(v.lbase, v.lofs, v.lsize);
      case (v.ev)
        3'd1: step(0, 0, 1, 0, 0, '0, '0, '0, '0);
        3'd2: step(0, 0, 0, 1, 0, '0, '0, '0, '0);
        3'd3: step(0, 0, 0, 0, 1, '0, '0, '0, lea + 32'd2);
        3'd4: step(0, 0, 0, 0, 1, '0, '0, '0, lea + 32'd4);
        default: idle();
      endcase
      stx_chk($sformatf("R1/R3/R4/R6/R7/R8/R11 vec%0d", i), v.sbase, v.sofs, v.ssize,
              v.exp_st, 0, 0, '0);
      idle();
      // R2 no status without a request
      check("R2 idle", {31'd0, status_valid_o}, 32'd0);
    end

    // R5 store with no reservation
    stx_chk("R5 open", 32'h6000, 8'd0, 2'b10, 1'b1, 0, 0, '0);
    // R9 second store after one load
    ldx(32'h6000, 8'd1, 2'b10);
    stx_chk("R9 first", 32'h6000, 8'd1, 2'b10, 1'b0, 0, 0, '0);
    stx_chk("R9 second", 32'h6000, 8'd1, 2'b10, 1'b1, 0, 0, '0);
    // R10 reload moves reservation
    ldx(32'h7000, 8'd0, 2'b10);
    ldx(32'h7100, 8'd0, 2'b01);
    stx_chk("R10 old", 32'h7000, 8'd0, 2'b10, 1'b1, 0, 0, '0);
    ldx(32'h7000, 8'd0, 2'b10);
    ldx(32'h7100, 8'd0, 2'b01);
    stx_chk("R10 new", 32'h7100, 8'd0, 2'b01, 1'b0, 0, 0, '0);
    // R6 clear coinciding with the store
    ldx(32'h8000, 8'd0, 2'b10);
    stx_chk("R6 same cycle", 32'h8000, 8'd0, 2'b10, 1'b1, 1, 0, '0);
    // R7 snoop coinciding with the store
    ldx(32'h8000, 8'd0, 2'b10);
    stx_chk("R7 same cycle", 32'h8000, 8'd0, 2'b10, 1'b1, 0, 1, 32'h8003);
    // R8 exception then reload restores pass
    ldx(32'h9000, 8'd0, 2'b00);
    step(0, 0, 0, 1, 0, '0, '0, '0, '0);
    ldx(32'h9000, 8'd0, 2'b00);
    stx_chk("R8 rearm", 32'h9000, 8'd0, 2'b00, 1'b0, 0, 0, '0);
    idle();
    check("R2 idle end", {31'd0, mem_wr_o}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule